// File: doc/BRIEF.md
# Flash Page Translation Controller

This block sits between a host that reads and writes numbered logical pages and a modelled flash array built from erase blocks. Flash pages cannot be rewritten in place. Each page can be programmed once, and it becomes writable again only after its whole block has been erased. The controller therefore writes every update to a fresh page and keeps a logical-to-physical map. The superseded copy is marked stale.

When the open block is full and only the reserved erased block is left, the controller reclaims a used block. It makes the reserved block the new open block and copies the victim's live pages into it. It then erases the victim over a multi-cycle busy period, and the erased victim becomes the new reserve. The controller keeps an erase count per block and uses it to choose which block to open next and to break ties between reclaim candidates.

Requests use a valid/ready handshake. Reads return after a fixed latency. A write is acknowledged only after its map entry has been committed, however much reclaim work the write had to wait for.

Top module: `ftl_top`

## Requirements
- R1: A read accepted on a clock edge (req_valid and req_ready high) raises rsp_valid with rsp_write=0 for exactly the next cycle. rsp_rdata then holds the data of the last acknowledged write to that logical page.
- R2: A read of a logical page that has never been written returns all ones on rsp_rdata (0xFF at the default 8-bit data width).
- R3: A write is acknowledged by one cycle of rsp_valid with rsp_write=1. With free space in the open block, the acknowledgement comes two cycles after acceptance. A read accepted after the acknowledgement returns the new data.
- R4: A rewrite of a logical page programs a previously unprogrammed physical page and invalidates the older copy. No physical page is ever programmed twice without an erase of its block in between.
- R5: An erase keeps the array busy for exactly ERASE_CYCLES cycles. During that time no page is programmed and req_ready stays low. A write that triggers a reclaim is acknowledged PG_PER_BLK+ERASE_CYCLES+5 cycles after acceptance.
- R6: Reclaim copies every still-valid page of the victim into the new open block and updates the map. All logical pages keep their data across any number of reclaims.
- R7: The reclaim victim is the used block with the fewest valid pages. Among blocks tied on valid pages, the one with the lowest erase count is chosen.
- R8: At least one erased block is held in reserve whenever a request can be accepted, so that every reclaim completes in a single pass.
- R9: When the open block fills while two or more erased blocks exist, the erased block with the lowest erase count is opened.
- R10: Out of reset req_ready is high and rsp_valid is low. req_ready is low from the cycle after a write is accepted until its acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lpn | input | LA_W | Logical page number |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_write | output | 1 | Response is a write acknowledgement |
| rsp_rdata | output | DATA_W | Read data (all ones when unmapped) |

## Verification
A read response is due on the cycle after acceptance. A plain write acknowledgement is due two cycles after acceptance. A reclaiming write is acknowledged PG_PER_BLK+ERASE_CYCLES+5 cycles after acceptance. The bench samples outputs on the falling edge after each of those rising edges, so every check lands on the exact cycle the result is due. While a write is pending, the bench checks req_ready and rsp_valid on every cycle and records the latency. Map, copy-forward and victim choices are checked against a behavioural model of logical page contents, using full read sweeps after each traffic pattern.

// File: rtl/ftl_pkg.sv
package ftl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PLACE,
        ST_COPY,
        ST_ERASE
    } ftl_state_e;

    function automatic int min_blocks_for(input int logical_pages, input int pages_per_blk);
        return (logical_pages + pages_per_blk - 1) / pages_per_blk + 2;
    endfunction

endpackage

// File: rtl/ftl_flash.sv
module ftl_flash #(
    parameter int NUM_BLK      = 4,
    parameter int PG_PER_BLK   = 32,
    parameter int DATA_W       = 8,
    parameter int ERASE_CYCLES = 8,
    localparam int BLK_W = $clog2(NUM_BLK),
    localparam int PG_W  = $clog2(PG_PER_BLK),
    localparam int PA_W  = BLK_W + PG_W,
    localparam int PHYS  = NUM_BLK * PG_PER_BLK,
    localparam int CNT_W = $clog2(ERASE_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic [PA_W-1:0]   prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [PA_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              erase_start,
    input  logic [BLK_W-1:0]  erase_blk,
    output logic              busy,
    output logic              erase_done
);

    logic [DATA_W-1:0] cells [PHYS];
    logic [CNT_W-1:0]  cnt;
    logic [BLK_W-1:0]  eblk;
    logic              finish;

    assign finish  = busy && (cnt == CNT_W'(ERASE_CYCLES - 1));
    assign rd_data = cells[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            cnt        <= '0;
            eblk       <= '0;
            erase_done <= 1'b0;
        end else begin
            erase_done <= 1'b0;
            if (erase_start) begin
                busy <= 1'b1;
                cnt  <= '0;
                eblk <= erase_blk;
            end else if (finish) begin
                busy       <= 1'b0;
                erase_done <= 1'b1;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (prog_en)
            cells[prog_addr] <= prog_data;
        if (finish)
            for (int p = 0; p < PG_PER_BLK; p++)
                cells[{eblk, PG_W'(p)}] <= '1;
    end

endmodule

// File: rtl/ftl_pick.sv
module ftl_pick #(
    parameter int NUM_BLK = 4,
    parameter int VC_W    = 6,
    parameter int EC_W    = 17,
    localparam int BLK_W  = $clog2(NUM_BLK)
) (
    input  logic [NUM_BLK-1:0]            eligible,
    input  logic [NUM_BLK-1:0][VC_W-1:0]  primary,
    input  logic [NUM_BLK-1:0][EC_W-1:0]  wear,
    output logic [BLK_W-1:0]              sel
);

    logic found;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int b = 0; b < NUM_BLK; b++) begin
            if (eligible[b] && (!found || primary[b] < primary[sel] ||
                (primary[b] == primary[sel] && wear[b] < wear[sel]))) begin
                sel   = BLK_W'(b);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ftl_top.sv
module ftl_top
    import ftl_pkg::*;
#(
    parameter int NUM_BLK      = 4,
    parameter int PG_PER_BLK   = 32,
    parameter int LOG_PAGES    = 64,
    parameter int DATA_W       = 8,
    parameter int ERASE_CYCLES = 8,
    parameter int EC_W         = 17,
    localparam int BLK_W = $clog2(NUM_BLK),
    localparam int PG_W  = $clog2(PG_PER_BLK),
    localparam int PA_W  = BLK_W + PG_W,
    localparam int PHYS  = NUM_BLK * PG_PER_BLK,
    localparam int LA_W  = $clog2(LOG_PAGES),
    localparam int VC_W  = $clog2(PG_PER_BLK + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [LA_W-1:0]   req_lpn,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_write,
    output logic [DATA_W-1:0] rsp_rdata
);

    initial begin
        if (NUM_BLK < min_blocks_for(LOG_PAGES, PG_PER_BLK))
            $error("ftl_top: too few blocks for the logical space");
    end

    ftl_state_e                    state;
    logic [PA_W-1:0]               map_pa [LOG_PAGES];
    logic [LA_W-1:0]               owner  [PHYS];
    logic [LOG_PAGES-1:0]          map_ok;
    logic [PHYS-1:0]               pg_valid;
    logic [NUM_BLK-1:0][VC_W-1:0]  vcnt, vcnt_n;
    logic [NUM_BLK-1:0][EC_W-1:0]  ec;
    logic [NUM_BLK-1:0]            blk_free;
    logic [BLK_W-1:0]              act_blk, vic, fsel, vsel;
    logic [PG_W:0]                 wr_ptr;
    logic [PG_W-1:0]               scan;
    logic [LA_W-1:0]               lat_lpn;
    logic [DATA_W-1:0]             lat_data;

    logic              room, prog_en, dec_en, take_en, rec_start;
    logic              erase_start, erase_done, flash_busy;
    logic [PA_W-1:0]   prog_addr, src, old_pa, rd_addr;
    logic [LA_W-1:0]   prog_lpn;
    logic [DATA_W-1:0] prog_data, rd_data;
    logic [BLK_W-1:0]  erase_blk, rec_blk;
    logic [NUM_BLK-1:0][VC_W-1:0] zero_vc;
    int                free_cnt;

    assign req_ready = (state == ST_IDLE);
    assign room      = (wr_ptr != (PG_W + 1)'(PG_PER_BLK));
    assign src       = {vic, scan};
    assign prog_addr = {act_blk, wr_ptr[PG_W-1:0]};
    assign rd_addr   = (state == ST_COPY) ? src : map_pa[req_lpn];
    assign prog_lpn  = (state == ST_COPY) ? owner[src] : lat_lpn;
    assign prog_data = (state == ST_COPY) ? rd_data : lat_data;
    assign prog_en   = (state == ST_PLACE && room) || (state == ST_COPY && pg_valid[src]);
    assign old_pa    = map_pa[prog_lpn];
    assign dec_en    = prog_en && map_ok[prog_lpn];
    assign free_cnt  = $countones(blk_free);
    assign take_en   = (state == ST_PLACE) && !room;
    assign rec_start = take_en && (free_cnt < 2);
    assign rec_blk   = vsel;
    assign erase_blk = vic;
    assign zero_vc   = '0;

    always_comb begin
        for (int b = 0; b < NUM_BLK; b++)
            vcnt_n[b] = vcnt[b]
                      + VC_W'(prog_en && act_blk == BLK_W'(b))
                      - VC_W'(dec_en && old_pa[PA_W-1:PG_W] == BLK_W'(b));
    end

    ftl_pick #(.NUM_BLK(NUM_BLK), .VC_W(VC_W), .EC_W(EC_W)) i_pick_free (
        .eligible (blk_free),
        .primary  (zero_vc),
        .wear     (ec),
        .sel      (fsel)
    );

    ftl_pick #(.NUM_BLK(NUM_BLK), .VC_W(VC_W), .EC_W(EC_W)) i_pick_victim (
        .eligible (~blk_free),
        .primary  (vcnt),
        .wear     (ec),
        .sel      (vsel)
    );

    ftl_flash #(
        .NUM_BLK(NUM_BLK), .PG_PER_BLK(PG_PER_BLK),
        .DATA_W(DATA_W), .ERASE_CYCLES(ERASE_CYCLES)
    ) i_flash (
        .clk         (clk),
        .rst         (rst),
        .prog_en     (prog_en),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .erase_start (erase_start),
        .erase_blk   (erase_blk),
        .busy        (flash_busy),
        .erase_done  (erase_done)
    );

    always_ff @(posedge clk) begin
        if (prog_en) begin
            map_pa[prog_lpn] <= prog_addr;
            owner[prog_addr] <= prog_lpn;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            rsp_valid   <= 1'b0;
            rsp_write   <= 1'b0;
            rsp_rdata   <= '0;
            map_ok      <= '0;
            pg_valid    <= '0;
            vcnt        <= '0;
            ec          <= '0;
            blk_free    <= {{(NUM_BLK - 1){1'b1}}, 1'b0};
            act_blk     <= '0;
            wr_ptr      <= '0;
            vic         <= '0;
            scan        <= '0;
            erase_start <= 1'b0;
            lat_lpn     <= '0;
            lat_data    <= '0;
        end else begin
            rsp_valid   <= 1'b0;
            erase_start <= 1'b0;
            vcnt        <= vcnt_n;
            if (prog_en) begin
                map_ok[prog_lpn]    <= 1'b1;
                pg_valid[prog_addr] <= 1'b1;
                wr_ptr              <= wr_ptr + 1'b1;
                if (dec_en)
                    pg_valid[old_pa] <= 1'b0;
            end
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_write) begin
                            lat_lpn  <= req_lpn;
                            lat_data <= req_wdata;
                            state    <= ST_PLACE;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_write <= 1'b0;
                            rsp_rdata <= map_ok[req_lpn] ? rd_data : '1;
                        end
                    end
                end
                ST_PLACE: begin
                    if (room) begin
                        rsp_valid <= 1'b1;
                        rsp_write <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        act_blk        <= fsel;
                        blk_free[fsel] <= 1'b0;
                        wr_ptr         <= '0;
                        if (free_cnt < 2) begin
                            vic   <= vsel;
                            scan  <= '0;
                            state <= ST_COPY;
                        end
                    end
                end
                ST_COPY: begin
                    scan <= scan + 1'b1;
                    if (scan == PG_W'(PG_PER_BLK - 1)) begin
                        erase_start <= 1'b1;
                        state       <= ST_ERASE;
                    end
                end
                ST_ERASE: begin
                    if (erase_done) begin
                        blk_free[vic] <= 1'b1;
                        if (ec[vic] != '1)
                            ec[vic] <= ec[vic] + 1'b1;
                        state <= ST_PLACE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ftl_checker.sv
module ftl_checker #(
    parameter int NUM_BLK      = 4,
    parameter int PG_PER_BLK   = 32,
    parameter int ERASE_CYCLES = 8,
    parameter int EC_W         = 17,
    localparam int BLK_W = $clog2(NUM_BLK),
    localparam int PG_W  = $clog2(PG_PER_BLK),
    localparam int PA_W  = BLK_W + PG_W,
    localparam int PHYS  = NUM_BLK * PG_PER_BLK,
    localparam int VC_W  = $clog2(PG_PER_BLK + 1)
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           req_valid,
    input logic                           req_ready,
    input logic                           req_write,
    input logic                           rsp_valid,
    input logic                           rsp_write,
    input logic                           prog_en,
    input logic [PA_W-1:0]                prog_addr,
    input logic                           erase_start,
    input logic                           erase_done,
    input logic [BLK_W-1:0]               erase_blk,
    input logic                           flash_busy,
    input logic [NUM_BLK-1:0]             blk_free,
    input logic [NUM_BLK-1:0][VC_W-1:0]   vcnt,
    input logic [NUM_BLK-1:0][EC_W-1:0]   ec,
    input logic                           take_en,
    input logic [BLK_W-1:0]               take_blk,
    input logic                           rec_start,
    input logic [BLK_W-1:0]               rec_blk
);

    logic [PHYS-1:0] written;
    int              busy_len;
    logic            vic_ok, take_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            written  <= '0;
            busy_len <= 0;
        end else begin
            if (prog_en)
                written[prog_addr] <= 1'b1;
            if (erase_done)
                for (int p = 0; p < PG_PER_BLK; p++)
                    written[{erase_blk, PG_W'(p)}] <= 1'b0;
            if (erase_start)
                busy_len <= 0;
            else if (flash_busy)
                busy_len <= busy_len + 1;
        end
    end

    always_comb begin
        vic_ok  = !blk_free[rec_blk];
        take_ok = blk_free[take_blk];
        for (int b = 0; b < NUM_BLK; b++) begin
            if (!blk_free[b] && (vcnt[b] < vcnt[rec_blk] ||
                (vcnt[b] == vcnt[rec_blk] && ec[b] < ec[rec_blk])))
                vic_ok = 1'b0;
            if (blk_free[b] && ec[b] < ec[take_blk])
                take_ok = 1'b0;
        end
    end

    a_r1_read_response: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write) |=> (rsp_valid && !rsp_write));

    a_r3_no_early_ack: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |=> (!rsp_valid && !req_ready));

    a_r4_program_once: assert property (@(posedge clk) disable iff (rst)
        prog_en |-> !written[prog_addr]);

    a_r5_no_program_in_erase: assert property (@(posedge clk) disable iff (rst)
        flash_busy |-> (!prog_en && !req_ready));

    a_r5_erase_length: assert property (@(posedge clk) disable iff (rst)
        erase_done |-> (busy_len == ERASE_CYCLES));

    a_r7_victim_choice: assert property (@(posedge clk) disable iff (rst)
        rec_start |-> vic_ok);

    a_r8_spare_reserved: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (blk_free != '0));

    a_r9_open_least_worn: assert property (@(posedge clk) disable iff (rst)
        take_en |-> take_ok);

endmodule

bind ftl_top ftl_checker #(
    .NUM_BLK(NUM_BLK), .PG_PER_BLK(PG_PER_BLK),
    .ERASE_CYCLES(ERASE_CYCLES), .EC_W(EC_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .rsp_valid   (rsp_valid),
    .rsp_write   (rsp_write),
    .prog_en     (prog_en),
    .prog_addr   (prog_addr),
    .erase_start (erase_start),
    .erase_done  (erase_done),
    .erase_blk   (erase_blk),
    .flash_busy  (flash_busy),
    .blk_free    (blk_free),
    .vcnt        (vcnt),
    .ec          (ec),
    .take_en     (take_en),
    .take_blk    (fsel),
    .rec_start   (rec_start),
    .rec_blk     (rec_blk)
);

// File: tb/test_ftl_top.sv
module test_ftl_top;

    localparam int PPB  = 32;
    localparam int LP   = 64;
    localparam int DW   = 8;
    localparam int ERC  = 8;
    localparam int LA_W = $clog2(LP);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [LA_W-1:0] req_lpn = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic            req_ready, rsp_valid, rsp_write;
    logic [DW-1:0]   rsp_rdata;

    int n_run = 0;
    int n_fail = 0;
    int max_lat = 0;
    int bad_ready = 0;
    int last_lat = 0;
    logic [DW-1:0] mdl [LP];
    bit            mok [LP];

    always #5 clk = ~clk;

    ftl_top i_ftl_top (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_lpn(req_lpn), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_ready();
        int g = 0;
        while (!req_ready && g < 5000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic do_read(input int lpn, input string req);
        logic [DW-1:0] exp;
        wait_ready();
        req_valid = 1'b1; req_write = 1'b0; req_lpn = LA_W'(lpn);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        exp = mok[lpn] ? mdl[lpn] : '1;
        check(rsp_valid && !rsp_write && rsp_rdata == exp, req,
              {rsp_valid, rsp_write, rsp_rdata}, {1'b1, 1'b0, exp});
    endtask

    task automatic do_write(input int lpn, input logic [DW-1:0] d);
        int lat;
        wait_ready();
        req_valid = 1'b1; req_write = 1'b1; req_lpn = LA_W'(lpn); req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 5000) begin
            if (req_ready) bad_ready++;
            @(negedge clk);
            lat++;
        end
        if (!rsp_valid || !rsp_write)
            check(1'b0, "R3 write ack", {rsp_valid, rsp_write}, 2'b11);
        mdl[lpn] = d;
        mok[lpn] = 1'b1;
        last_lat = lat;
        if (lat > max_lat) max_lat = lat;
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < LP; i++) do_read(i, req);
    endtask

    initial begin
        for (int i = 0; i < LP; i++) begin mdl[i] = '0; mok[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: idle after reset
        check(req_ready && !rsp_valid, "R10 reset state", {req_ready, rsp_valid}, 2'b10);
        // R2: unmapped read gives all ones
        do_read(5, "R2 unmapped read");
        // R3: first write acknowledged two cycles after acceptance
        do_write(3, 8'hA5);
        check(last_lat == 2, "R3 write latency", last_lat, 2);
        check(req_ready, "R10 ready after ack", req_ready, 1);
        do_read(3, "R1 R3 read after write");
        // R4: rewrite lands on a fresh page, new data visible
        do_write(3, 8'h5A);
        do_read(3, "R4 rewrite read");
        do_read(4, "R2 neighbour still unmapped");
        for (int k = 0; k < 40; k++) do_write(7, DW'(k));
        do_read(7, "R4 repeated rewrite");
        do_read(3, "R4 other page intact");
        // R6: fill every logical page, then rewrite in several orders
        for (int i = 0; i < LP; i++) do_write(i, DW'(i * 7 + 1));
        sweep("R6 after fill");
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < LP; i++) begin
                int l = (r[0]) ? ((i * 5 + r) % LP) : (LP - 1 - i);
                do_write(l, DW'(l * 3 + r * 29 + 2));
            end
            sweep("R6 R7 R9 after rewrite round");
        end
        // R7 R8: hot set churn forces reclaims with skewed valid counts
        for (int k = 0; k < 60; k++) do_write(k % 4, DW'(k + 100));
        sweep("R6 R7 R8 after hot churn");
        // R5 R8: reclaim write latency includes the full erase window
        check(max_lat == PPB + ERC + 5, "R5 R8 reclaim latency", max_lat, PPB + ERC + 5);
        check(bad_ready == 0, "R10 ready low while write pending", bad_ready, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule